// File: doc/BRIEF.md
# Key-Protected SRAM Wipe Controller

This block wipes a small on-chip SRAM on request. Software sees one control/status register at offset 0x18 and one key register at offset 0x24. Writing 1 to the start bit of the control/status register makes the block walk the SRAM from the lowest word to the highest and write zero into each word, one word per clock. The start bit is locked. Software can set it only after a two-write unlock sequence has been written to the key register.

A busy flag in the same register shows when a wipe is running. The start bit clears itself at the moment the wipe completes. Each unlock is good for one wipe only. A wrong key value cancels any unlock, whether it is partly or fully written. Register accesses continue to work while a wipe runs, so software can unlock again during a wipe and start the next wipe once the current one ends. Read data is registered: it appears one clock after the address is presented.

Top module: `sram_wipe_ctrl`

## Requirements
- R1: After reset the control/status register reads 0x00000000, busy is 0 and `mem_we` stays low.
- R2: The key register unlocks the start bit after two writes in order: first 0x000000CA, then 0x00000053. After that, writing a 1 in bit 0 of offset 0x18 starts a wipe. From the next clock, bit 0 (start) and bit 1 (busy) both read 1.
- R3: A write of 1 to bit 0 with no unlock in place is ignored. The register stays 0 and the SRAM is not written. A write of 1 to any other offset never starts a wipe.
- R4: Any key write that is not the value the sequence expects next returns the lock to its initial state. This applies to a wrong value between the two keys and to any key write after the unlock is complete.
- R5: Starting a wipe uses up the unlock. A later write of 1 to bit 0 without a fresh key sequence is ignored.
- R6: A wipe raises `mem_we` for exactly DEPTH consecutive cycles. It writes addresses 0, 1, …, DEPTH-1 in that order, with `mem_wdata` equal to zero.
- R7: Busy and the start bit fall together in the cycle after the cycle that writes address DEPTH-1. The register then reads 0.
- R8: A write of 1 to bit 0 while a wipe is running has no effect, even with a valid unlock in place. The sweep neither restarts nor stretches, and the unlock stays in place.
- R9: Bits 31:2 of the control/status register always read 0 and ignore writes. The key register and unused offsets read 0.
- R10: Key and register accesses are serviced during a wipe. A key sequence written during a wipe allows the next wipe to start as soon as busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, one cycle after the address |
| mem_we | output | 1 | SRAM write enable during a wipe |
| mem_addr | output | MEM_AW (6) | SRAM word address |
| mem_wdata | output | MEM_DW (32) | SRAM write data, always zero |

## Verification
The bench targets the corner cases of the unlock sequence:
- a wrong value between the two keys, which a loose compare would let through as an unlock;
- a stray key write after a complete unlock;
- a second start with no new keys, which a design that never clears the unlock would accept.

It also issues a start while a wipe runs with a fresh unlock already in place. A design that only checks the unlock would restart the sweep at address 0. A scoreboard catches that as an out-of-order address or as extra writes. While one wipe runs, the control/status register is read on every cycle. A design whose busy flag drops one cycle early or late, or whose start bit clears apart from busy, fails that cycle-by-cycle comparison.

// File: rtl/sram_wipe_pkg.sv
package sram_wipe_pkg;

   typedef enum logic [1:0] {
      KEY_LOCKED = 2'd0,
      KEY_HALF   = 2'd1,
      KEY_OPEN   = 2'd2
   } key_state_e;

   localparam int CSR_START_BIT = 0;
   localparam int CSR_BUSY_BIT  = 1;

endpackage

// File: rtl/wipe_key_gate.sv
module wipe_key_gate
   import sram_wipe_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter logic [7:0]  KEY_FIRST  = 8'hCA,
   parameter logic [7:0]  KEY_SECOND = 8'h53
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_we,
   input  logic [DATA_W-1:0] key_data,
   input  logic              consume,
   output logic              unlocked
);

   localparam logic [DATA_W-1:0] FIRST_W  = DATA_W'(KEY_FIRST);
   localparam logic [DATA_W-1:0] SECOND_W = DATA_W'(KEY_SECOND);

   key_state_e state_q;
   key_state_e state_d;

   always_comb begin
      state_d = state_q;
      if (consume) begin
         state_d = KEY_LOCKED;
      end else if (key_we) begin
         unique case (state_q)
            KEY_LOCKED: state_d = (key_data == FIRST_W)  ? KEY_HALF : KEY_LOCKED;
            KEY_HALF:   state_d = (key_data == SECOND_W) ? KEY_OPEN : KEY_LOCKED;
            default:    state_d = KEY_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= KEY_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == KEY_OPEN);

endmodule

// File: rtl/wipe_sweeper.sv
module wipe_sweeper #(
   parameter int DEPTH  = 64,
   parameter int MEM_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              last,
   output logic [MEM_AW-1:0] addr
);

   localparam logic [MEM_AW-1:0] LAST_ADDR = MEM_AW'(DEPTH - 1);

   logic              busy_q;
   logic [MEM_AW-1:0] cnt_q;

   assign last = busy_q && (cnt_q == LAST_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (last) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign busy = busy_q;
   assign addr = cnt_q;

endmodule

// File: rtl/wipe_csr.sv
module wipe_csr
   import sram_wipe_pkg::*;
#(
   parameter int                DATA_W  = 32,
   parameter int                ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] CSR_OFS = 'h18,
   parameter logic [ADDR_W-1:0] KEY_OFS = 'h24,
   parameter bit                RD_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              unlocked,
   input  logic              busy,
   input  logic              done,
   output logic              start,
   output logic              key_we,
   output logic              erase_bit,
   output logic [DATA_W-1:0] bus_rdata
);

   logic              hit_csr;
   logic              erase_q;
   logic [DATA_W-1:0] rd_next;

   assign hit_csr = (bus_addr == CSR_OFS);
   assign key_we  = bus_we && (bus_addr == KEY_OFS);
   assign start   = bus_we && hit_csr && bus_wdata[CSR_START_BIT] && unlocked && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n)     erase_q <= 1'b0;
      else if (start) erase_q <= 1'b1;
      else if (done)  erase_q <= 1'b0;
   end

   assign erase_bit = erase_q;

   always_comb begin
      rd_next = '0;
      if (hit_csr) begin
         rd_next[CSR_START_BIT] = erase_q;
         rd_next[CSR_BUSY_BIT]  = busy;
      end
   end

   generate
      if (RD_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_next;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_next;
      end
   endgenerate

endmodule

// File: rtl/sram_wipe_ctrl.sv
module sram_wipe_ctrl #(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 32,
   parameter int                DEPTH      = 64,
   parameter int                MEM_DW     = 32,
   parameter logic [ADDR_W-1:0] CSR_OFS    = 'h18,
   parameter logic [ADDR_W-1:0] KEY_OFS    = 'h24,
   parameter logic [7:0]        KEY_FIRST  = 8'hCA,
   parameter logic [7:0]        KEY_SECOND = 8'h53,
   parameter bit                RD_REG     = 1'b1,
   localparam int               MEM_AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [MEM_DW-1:0] mem_wdata
);

   generate
      if (DEPTH < 2)            begin : g_bad_depth $error("DEPTH must be at least 2");          end
      if (DATA_W < 8)           begin : g_bad_dw    $error("DATA_W must hold a key byte");       end
      if (MEM_DW < 1)           begin : g_bad_mdw   $error("MEM_DW must be positive");           end
      if (CSR_OFS == KEY_OFS)   begin : g_bad_ofs   $error("register offsets must differ");      end
      if (KEY_FIRST == KEY_SECOND) begin : g_bad_key $error("the two keys must differ");         end
   endgenerate

   logic unlocked_w;
   logic start_w;
   logic key_we_w;
   logic busy_w;
   logic last_w;
   logic erase_w;

   wipe_key_gate #(
      .DATA_W     (DATA_W),
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND)
   ) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_we   (key_we_w),
      .key_data (bus_wdata),
      .consume  (start_w),
      .unlocked (unlocked_w)
   );

   wipe_sweeper #(
      .DEPTH  (DEPTH),
      .MEM_AW (MEM_AW)
   ) u_sweep (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_w),
      .busy  (busy_w),
      .last  (last_w),
      .addr  (mem_addr)
   );

   wipe_csr #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .CSR_OFS (CSR_OFS),
      .KEY_OFS (KEY_OFS),
      .RD_REG  (RD_REG)
   ) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .unlocked  (unlocked_w),
      .busy      (busy_w),
      .done      (last_w),
      .start     (start_w),
      .key_we    (key_we_w),
      .erase_bit (erase_w),
      .bus_rdata (bus_rdata)
   );

   assign mem_we    = busy_w;
   assign mem_wdata = '0;

endmodule

// File: rtl/wipe_ctrl_chk.sv
module wipe_ctrl_chk #(
   parameter int                ADDR_W  = 8,
   parameter int                DATA_W  = 32,
   parameter int                DEPTH   = 64,
   parameter int                MEM_AW  = 6,
   parameter logic [ADDR_W-1:0] CSR_OFS = 'h18
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              mem_we,
   input logic [MEM_AW-1:0] mem_addr,
   input logic              busy,
   input logic              erase_bit,
   input logic              unlocked
);

   localparam logic [MEM_AW-1:0] LAST_ADDR = MEM_AW'(DEPTH - 1);

   // R2
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(unlocked && bus_we && (bus_addr == CSR_OFS) && bus_wdata[0]));

   // R5
   unlock_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !unlocked);

   // R6
   first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> (mem_addr == '0));

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   // R7
   sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we) |-> ($past(mem_addr) == LAST_ADDR));

   // R7
   start_busy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_bit == busy);

   // R9
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:2] == '0);

endmodule

bind sram_wipe_ctrl wipe_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .DEPTH   (DEPTH),
   .MEM_AW  (MEM_AW),
   .CSR_OFS (CSR_OFS)
) u_wipe_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .busy      (busy_w),
   .erase_bit (erase_w),
   .unlocked  (unlocked_w)
);

// File: tb/test_sram_wipe_ctrl.sv
module test_sram_wipe_ctrl;

   localparam int DEPTH = 64;
   localparam int AW    = $clog2(DEPTH);
   localparam logic [7:0] CSR = 8'h18;
   localparam logic [7:0] KEY = 8'h24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;

   int checks = 0;
   int fails  = 0;
   bit watch  = 1'b0;
   bit prev_we = 1'b0;
   int exp_q[$];

   always #4 clk = ~clk;

   sram_wipe_ctrl i_sram_wipe_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_addr = a;
      @(negedge clk);
      v = bus_rdata;
   endtask

   task automatic push_sweep();
      for (int i = 0; i < DEPTH; i++) exp_q.push_back(i);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor: compares every SRAM write with the queue
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (watch) chk(bus_rdata == (prev_we ? 32'h3 : 32'h0), "R7 csr per cycle",
                        bus_rdata, prev_we ? 32'h3 : 32'h0);
         if (mem_we) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6 unexpected write", 32'(mem_addr), 32'hFFFFFFFF);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(32'(mem_addr) == 32'(e) && mem_wdata == '0, "R6 sweep word",
                   32'(mem_addr), 32'(e));
            end
         end
         prev_we = mem_we;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(mem_we == 1'b0, "R1 mem_we", 32'(mem_we), 0);
      rd(CSR, v); chk(v == 0, "R1 csr", v, 0);
      rd(KEY, v); chk(v == 0, "R1 key reads", v, 0);

      // R3 locked start and other offset
      wr(CSR, 32'h1); idle(6);
      rd(CSR, v); chk(v == 0, "R3 locked start", v, 0);
      wr(8'h1C, 32'h1); idle(6);
      rd(CSR, v); chk(v == 0, "R3 other offset", v, 0);

      // R2 / R6 / R7: unlocked wipe with per-cycle status watch
      wr(KEY, 32'hCA); wr(KEY, 32'h53);
      bus_addr = CSR;
      @(negedge clk);
      watch = 1'b1;
      push_sweep();
      wr(CSR, 32'h1);
      idle(2);
      chk(mem_we == 1'b1, "R2 wipe started", 32'(mem_we), 1);
      idle(DEPTH + 4);
      watch = 1'b0;
      chk(exp_q.size() == 0, "R6 all words written", exp_q.size(), 0);
      rd(CSR, v); chk(v == 0, "R7 after wipe", v, 0);

      // R5 unlock spent
      wr(CSR, 32'h1); idle(6);
      rd(CSR, v); chk(v == 0, "R5 second start ignored", v, 0);

      // R4 wrong value between keys
      wr(KEY, 32'hCA); wr(KEY, 32'h11); wr(KEY, 32'h53);
      wr(CSR, 32'h1); idle(6);
      rd(CSR, v); chk(v == 0, "R4 broken sequence", v, 0);
      // R4 stray key after full unlock
      wr(KEY, 32'hCA); wr(KEY, 32'h53); wr(KEY, 32'h00);
      wr(CSR, 32'h1); idle(6);
      rd(CSR, v); chk(v == 0, "R4 stray key cancels", v, 0);

      // R8 / R10: start during wipe with fresh unlock
      wr(KEY, 32'hCA); wr(KEY, 32'h53);
      push_sweep();
      wr(CSR, 32'h1);
      wr(KEY, 32'hCA); wr(KEY, 32'h53);
      wr(CSR, 32'h1);
      rd(CSR, v); chk(v == 32'h3, "R8 busy during wipe", v, 32'h3);
      idle(DEPTH + 4);
      chk(exp_q.size() == 0, "R8 no restart", exp_q.size(), 0);
      rd(CSR, v); chk(v == 0, "R8 idle after", v, 0);
      push_sweep();
      wr(CSR, 32'h1);
      idle(DEPTH + 4);
      chk(exp_q.size() == 0, "R10 unlock from wipe used", exp_q.size(), 0);
      rd(CSR, v); chk(v == 0, "R10 idle after", v, 0);

      // R9 reserved bits and other reads
      wr(CSR, 32'hFFFFFFFC);
      rd(CSR, v); chk(v == 0, "R9 reserved write", v, 0);
      wr(KEY, 32'hCA);
      rd(KEY, v); chk(v == 0, "R9 key reads zero", v, 0);
      wr(KEY, 32'h53);
      push_sweep();
      wr(CSR, 32'hFFFFFFFF);
      rd(CSR, v); chk(v == 32'h3, "R9 only low bits", v, 32'h3);
      rd(8'h20, v); chk(v == 0, "R9 unused offset", v, 0);
      idle(DEPTH + 4);
      chk(exp_q.size() == 0, "R9 wipe done", exp_q.size(), 0);
      rd(CSR, v); chk(v == 0, "R9 idle", v, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule